// File: doc/BRIEF.md
# Indexed Configuration Byte Store

This block puts a two-strobe indexed access scheme in front of a small byte array that holds machine configuration and clock status. The host first writes an index byte; its low seven bits choose a byte address and its top bit is kept as a mask for the non-maskable interrupt, driven straight out on a pin of its own. Later data-port strobes read or write the byte that the index selects. Every data access uses the index most recently written, so a run of data accesses needs only one index write.

A few locations follow status-register rules. Two bytes cannot be written at all. One byte has a read-only top bit. One byte reports the state of the backup supply in its top bit. The array holds 128 bytes by default. A 64-byte build folds the upper half of the index space onto the lower half.

A checksum engine, started by a one-cycle strobe, adds the configuration bytes from 10h through 2Dh into a 16-bit total. It compares that total with the word stored at 2Eh (high byte) and 2Fh (low byte), then gives a one-cycle done pulse and a held match flag. The engine has three states. `SUM_IDLE` waits for the start strobe and goes to `SUM_ACCUM` when the strobe arrives. `SUM_ACCUM` adds one byte per cycle and goes to `SUM_CHECK` after it adds byte 2Dh. `SUM_CHECK` produces the result and returns to `SUM_IDLE`.

Top module: `cfgram_port`

## Requirements
- R1: `data_wr` stores `wdata` at the address in index bits 6:0. `data_rd` loads `rdata` with the addressed byte on the next clock edge. `rdata` holds its value until the next `data_rd`. A data access uses the index as it was before any index write in the same cycle.
- R2: `nmi_mask` equals bit 7 of the last byte written with `idx_wr`, where 1 means disabled and 0 means enabled. It changes only on an index write.
- R3: After reset the index is 00h, `nmi_mask` is 0, every byte is 00h, and `rdata`, `sum_done` and `sum_ok` are 0. A data access made before any index write goes to address 00h.
- R4: With `MEM_BYTES` = 64, index values 40h–7Fh reach the same bytes as 00h–3Fh. With 128, they are separate bytes.
- R5: Data writes to address 0Ch or 0Dh are discarded. Byte 0Ch keeps reading 00h.
- R6: A data write to 0Ah changes only bits 6:0. Bit 7 keeps reading 0.
- R7: A read of 0Dh returns `supply_good` in bit 7 and 0 in bits 6:0.
- R8: After a check, `sum_ok` is 1 exactly when the 16-bit sum of bytes 10h–2Dh equals {byte 2Eh, byte 2Fh}.
- R9: `sum_done` is high for one cycle, 31 clock edges after the edge that samples `sum_start`. A `sum_start` that arrives while a check is running is ignored. `sum_ok` changes only together with `sum_done`.
- R10: Bytes 00h–0Fh and 30h–33h have no effect on the checksum result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_wr | input | 1 | Index write strobe |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe |
| wdata | input | 8 | Write data for the index and data strobes |
| supply_good | input | 1 | Backup supply status, reported in byte 0Dh bit 7 |
| sum_start | input | 1 | Starts a checksum check |
| rdata | output | 8 | Registered read data |
| nmi_mask | output | 1 | 1 disables NMI, 0 enables it |
| sum_done | output | 1 | One-cycle pulse when a check ends |
| sum_ok | output | 1 | Result of the last check |

## Verification
A 128-byte instance and a 64-byte instance receive the same stimulus. Writes through high index values therefore show up as aliases in the small array only, which separates correct folding from a missing or misplaced address mask. Writes of all-ones to the protected and half-protected bytes tell discarded writes apart from partial writes. Toggling the supply input between two reads of 0Dh separates a live status bit from a stored one. The checksum runs once with a matching stored word and once with a single stored byte changed, while junk is present in the excluded ranges. A second start strobe during the run shows whether the engine restarts.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;
    localparam int IDX_ADDR_BITS = 7;

    localparam logic [6:0] LOC_RATE  = 7'h0A;
    localparam logic [6:0] LOC_FLAG  = 7'h0C;
    localparam logic [6:0] LOC_STAT  = 7'h0D;
    localparam logic [6:0] SUM_FIRST = 7'h10;
    localparam logic [6:0] SUM_LAST  = 7'h2D;
    localparam logic [6:0] SUM_HI    = 7'h2E;
    localparam logic [6:0] SUM_LO    = 7'h2F;

    typedef enum logic [1:0] {
        SUM_IDLE,
        SUM_ACCUM,
        SUM_CHECK
    } sum_state_e;
endpackage

// File: rtl/cfgram_index.sv
module cfgram_index (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (idx_wr) begin
            idx_q <= wdata;
        end
    end
endmodule

// File: rtl/cfgram_store.sv
module cfgram_store
    import cfgram_pkg::*;
#(
    parameter int MEM_BYTES = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [6:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        supply_good,
    input  logic [6:0]  sum_ptr,
    output logic [7:0]  rdata,
    output logic [7:0]  sum_byte,
    output logic [15:0] chk_word
);
    localparam int AW = $clog2(MEM_BYTES);

    logic [7:0]    mem [MEM_BYTES];
    logic [AW-1:0] pa;
    logic [AW-1:0] sa;
    logic [7:0]    rd_value;
    logic          pa_locked;

    assign pa = addr[AW-1:0];
    assign sa = sum_ptr[AW-1:0];

    generate
        if (AW < IDX_ADDR_BITS) begin : g_fold
            logic unused_hi;
            assign unused_hi = ^{addr[IDX_ADDR_BITS-1:AW], sum_ptr[IDX_ADDR_BITS-1:AW]};
        end
    endgenerate

    assign pa_locked = (pa == AW'(LOC_FLAG)) || (pa == AW'(LOC_STAT));
    assign rd_value  = (pa == AW'(LOC_STAT)) ? {supply_good, 7'b0} : mem[pa];
    assign sum_byte  = mem[sa];
    assign chk_word  = {mem[AW'(SUM_HI)], mem[AW'(SUM_LO)]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem[i] <= 8'h00;
            end
            rdata <= 8'h00;
        end else begin
            if (wr_en && !pa_locked) begin
                if (pa == AW'(LOC_RATE)) begin
                    mem[pa][6:0] <= wdata[6:0];
                end else begin
                    mem[pa] <= wdata;
                end
            end
            if (rd_en) begin
                rdata <= rd_value;
            end
        end
    end
endmodule

// File: rtl/cfgram_sum.sv
module cfgram_sum
    import cfgram_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  byte_in,
    input  logic [15:0] chk_word,
    output logic [6:0]  ptr,
    output logic        done,
    output logic        ok
);
    sum_state_e  state_q, state_d;
    logic [15:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SUM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE:  if (start) state_d = SUM_ACCUM;
            SUM_ACCUM: if (ptr == SUM_LAST) state_d = SUM_CHECK;
            SUM_CHECK: state_d = SUM_IDLE;
            default:   state_d = SUM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= 16'h0000;
            ptr  <= SUM_FIRST;
            done <= 1'b0;
            ok   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                SUM_IDLE: begin
                    acc <= 16'h0000;
                    ptr <= SUM_FIRST;
                end
                SUM_ACCUM: begin
                    acc <= acc + {8'h00, byte_in};
                    ptr <= ptr + 7'd1;
                end
                SUM_CHECK: begin
                    done <= 1'b1;
                    ok   <= (acc == chk_word);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfgram_port.sv
module cfgram_port #(
    parameter int MEM_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    input  logic       supply_good,
    input  logic       sum_start,
    output logic [7:0] rdata,
    output logic       nmi_mask,
    output logic       sum_done,
    output logic       sum_ok
);
    logic [7:0]  idx_q;
    logic [6:0]  sum_ptr;
    logic [7:0]  sum_byte;
    logic [15:0] chk_word;

    cfgram_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (wdata),
        .idx_q  (idx_q)
    );

    cfgram_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (data_wr),
        .rd_en       (data_rd),
        .addr        (idx_q[6:0]),
        .wdata       (wdata),
        .supply_good (supply_good),
        .sum_ptr     (sum_ptr),
        .rdata       (rdata),
        .sum_byte    (sum_byte),
        .chk_word    (chk_word)
    );

    cfgram_sum u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sum_start),
        .byte_in  (sum_byte),
        .chk_word (chk_word),
        .ptr      (sum_ptr),
        .done     (sum_done),
        .ok       (sum_ok)
    );

    assign nmi_mask = idx_q[7];
endmodule

// File: rtl/cfgram_port_chk.sv
module cfgram_port_chk #(
    parameter int MEM_BYTES = 128
) (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_wr,
    input logic       data_rd,
    input logic [7:0] wdata,
    input logic       supply_good,
    input logic [7:0] idx_q,
    input logic [7:0] rdata,
    input logic       nmi_mask,
    input logic       sum_done,
    input logic       sum_ok
);
    localparam int AW = $clog2(MEM_BYTES);

    AST_NMI_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (nmi_mask == $past(wdata[7]))); // R2
    AST_NMI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(nmi_mask)); // R2
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(rdata)); // R1
    AST_STAT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (idx_q[AW-1:0] == AW'(7'h0D))) |=> (rdata == {$past(supply_good), 7'b0})); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sum_done |=> !sum_done); // R9
    AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_done |-> $stable(sum_ok)); // R9
endmodule

bind cfgram_port cfgram_port_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_wr      (idx_wr),
    .data_rd     (data_rd),
    .wdata       (wdata),
    .supply_good (supply_good),
    .idx_q       (idx_q),
    .rdata       (rdata),
    .nmi_mask    (nmi_mask),
    .sum_done    (sum_done),
    .sum_ok      (sum_ok)
);

// File: tb/cfgram_port_bench.sv
module cfgram_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0, sum_start = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       supply_good = 1'b1;
    logic [7:0] rdata_b, rdata_s;
    logic       nmi_b, nmi_s, done_b, done_s, ok_b, ok_s;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgram_port u_cfgram_port (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(wdata), .supply_good(supply_good), .sum_start(sum_start),
        .rdata(rdata_b), .nmi_mask(nmi_b), .sum_done(done_b), .sum_ok(ok_b)
    );

    cfgram_port #(.MEM_BYTES(64)) u_small (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr), .data_rd(data_rd),
        .wdata(wdata), .supply_good(supply_good), .sum_start(sum_start),
        .rdata(rdata_s), .nmi_mask(nmi_s), .sum_done(done_s), .sum_ok(ok_s)
    );

    // Behavioural reference: [0] = 128-byte build, [1] = 64-byte build
    int m_mem [2][128];
    int m_idx;
    int m_rd [2];
    int m_busy [2];
    int m_cnt [2];
    int m_done [2];
    int m_ok [2];
    int m_size [2] = '{128, 64};

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0;
            for (int k = 0; k < 2; k++) begin
                for (int a = 0; a < 128; a++) m_mem[k][a] = 0;
                m_rd[k] = 0; m_busy[k] = 0; m_cnt[k] = 0; m_done[k] = 0; m_ok[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                int a;
                int sum;
                a = (m_idx % 128) % m_size[k];
                m_done[k] = 0;
                if (m_busy[k] != 0) begin
                    m_cnt[k]--;
                    if (m_cnt[k] == 0) begin
                        sum = 0;
                        for (int s = 16'h10; s <= 16'h2D; s++) sum += m_mem[k][s];
                        m_done[k] = 1;
                        m_ok[k] = ((sum & 16'hFFFF) == (m_mem[k][16'h2E] * 256 + m_mem[k][16'h2F])) ? 1 : 0;
                        m_busy[k] = 0;
                    end
                end else if (sum_start) begin
                    m_busy[k] = 1;
                    m_cnt[k] = 31;
                end
                if (data_rd) m_rd[k] = (a == 13) ? (supply_good ? 8'h80 : 8'h00) : m_mem[k][a];
                if (data_wr && a != 12 && a != 13) begin
                    if (a == 10) m_mem[k][a] = (m_mem[k][a] & 8'h80) | (int'(wdata) & 8'h7F);
                    else m_mem[k][a] = int'(wdata);
                end
            end
            if (idx_wr) m_idx = int'(wdata);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 rdata big",    16'(rdata_b), 16'(m_rd[0]));
            chk("R1 rdata small",  16'(rdata_s), 16'(m_rd[1]));
            chk("R2 nmi big",      16'(nmi_b),   16'(m_idx / 128));
            chk("R2 nmi small",    16'(nmi_s),   16'(m_idx / 128));
            chk("R9 done big",     16'(done_b),  16'(m_done[0]));
            chk("R9 done small",   16'(done_s),  16'(m_done[1]));
            chk("R8 ok big",       16'(ok_b),    16'(m_ok[0]));
            chk("R8 ok small",     16'(ok_s),    16'(m_ok[1]));
        end
    end

    task automatic op_idx(input logic [7:0] v);
        idx_wr = 1'b1; wdata = v; @(negedge clk); idx_wr = 1'b0;
    endtask
    task automatic op_wr(input logic [7:0] v);
        data_wr = 1'b1; wdata = v; @(negedge clk); data_wr = 1'b0;
    endtask
    task automatic op_rd;
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    endtask
    task automatic op_start;
        sum_start = 1'b1; @(negedge clk); sum_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int total;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset rdata", 16'(rdata_b), 16'h0);
        chk("R3 reset nmi",   16'(nmi_b),   16'h0);
        chk("R3 reset ok",    16'(ok_b),    16'h0);
        op_rd;
        chk("R3 read without index", 16'(rdata_b), 16'h0);
        op_wr(8'h5A); op_rd;
        chk("R3 write without index", 16'(rdata_b), 16'h5A);

        op_idx(8'hA1);
        chk("R2 nmi disabled", 16'(nmi_b), 16'h1);
        op_wr(8'hC3); op_rd;
        chk("R1 data at 21h", 16'(rdata_b), 16'hC3);
        op_idx(8'h21);
        chk("R2 nmi enabled", 16'(nmi_b), 16'h0);
        op_rd;
        chk("R1 same byte via clear mask", 16'(rdata_b), 16'hC3);

        op_idx(8'h0C); op_wr(8'hFF); op_rd;
        chk("R5 0Ch write discarded", 16'(rdata_b), 16'h00);
        op_idx(8'h0D); op_wr(8'hFF);
        supply_good = 1'b1; op_rd;
        chk("R7 supply good", 16'(rdata_b), 16'h80);
        supply_good = 1'b0; op_rd;
        chk("R7 supply failed", 16'(rdata_b), 16'h00);
        chk("R5 0Dh write discarded", 16'(rdata_b), 16'h00);
        supply_good = 1'b1;
        op_idx(8'h0A); op_wr(8'hFF); op_rd;
        chk("R6 0Ah top bit read-only", 16'(rdata_b), 16'h7F);

        op_idx(8'h45); op_wr(8'h3C);
        op_idx(8'h05); op_rd;
        chk("R4 small mirrors 45h onto 05h", 16'(rdata_s), 16'h3C);
        chk("R4 big keeps 05h separate", 16'(rdata_b), 16'h00);

        total = 0;
        for (int a = 16'h10; a <= 16'h2D; a++) begin
            logic [7:0] v;
            v = 8'((a * 37 + 11) & 8'hFF);
            total += int'(v);
            op_idx(8'(a)); op_wr(v);
        end
        op_idx(8'h2E); op_wr(8'((total >> 8) & 8'hFF));
        op_idx(8'h2F); op_wr(8'(total & 8'hFF));
        op_idx(8'h30); op_wr(8'hFF);
        op_idx(8'h33); op_wr(8'hEE);
        op_idx(8'h07); op_wr(8'h99);
        op_start;
        repeat (5) @(negedge clk);
        op_start;
        repeat (40) @(negedge clk);
        chk("R8 R10 match big",   16'(ok_b), 16'h1);
        chk("R8 R10 match small", 16'(ok_s), 16'h1);

        op_idx(8'h2F); op_wr(8'((total + 1) & 8'hFF));
        op_start;
        repeat (40) @(negedge clk);
        chk("R8 mismatch big",   16'(ok_b), 16'h0);
        chk("R8 mismatch small", 16'(ok_s), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule